// File: doc/BRIEF.md
# Video DRAM Refresh Cycle Decoder

This block sits on the device side of a multiport video DRAM and watches the row strobe, column strobe, write enable, special-function select and row address pins. When the row strobe falls it decides what kind of cycle is starting. The cycle is one of the following:

- a refresh of the row on the address pins;
- a counter-driven refresh that also wipes the special-mode and persistent write-mask state;
- a counter-driven refresh that keeps that state;
- a reserved combination;
- an ordinary access.

For each refresh it emits one strobe, the row to refresh and a code for the refresh kind. It keeps the data outputs disabled for the whole refresh cycle.

All pins are active low except the special-function select. They are sampled by one register stage on the block clock. The special-mode and mask registers are loaded through a side port. They power up holding an undefined pattern until the first clearing refresh zeroes them. The internal row counter is cleared by reset, steps once after each counter-driven refresh, and wraps at the last row.

Top module: `vram_refresh_decoder`

## Requirements
- R1: If the column strobe is high when the row strobe falls and stays high until the row strobe rises, the block gives one `refresh_stb` pulse after the rise. With it, `refresh_row` equals the address sampled at the fall and `refresh_kind` is 0.
- R2: If the column strobe is already low when the row strobe falls and `dsf` is 0, the block refreshes the counter row with `refresh_kind` 1. In that same strobe cycle `mode_q` and `mask_q` read zero. The level of `we_n` does not matter in this case.
- R3: If the column strobe is low at the fall with `dsf`=1 and `we_n`=1, the block refreshes the counter row with `refresh_kind` 2. `mode_q` and `mask_q` are left unchanged.
- R4: The row counter starts at 0 after reset. It advances by one after each kind 1 or kind 2 refresh and wraps from 2^ROW_W-1 to 0. Kind 0 refreshes, reserved cycles and ordinary accesses leave it unchanged.
- R5: A kind 0 refresh leaves `mode_q` and `mask_q` unchanged.
- R6: If the column strobe is low at the fall with `dsf`=1 and `we_n`=0, the block gives one `rsv_err` pulse. There is no refresh strobe, and the counter, mode and mask are unchanged.
- R7: `dq_oe` stays 0 for the whole of every refresh and reserved cycle.
- R8: If the column strobe falls only while the row strobe is already low, the cycle is an ordinary access and produces no refresh strobe. During the access `dq_oe` is 1 while the column strobe is low and `we_n` is 1.
- R9: A `cfg_load` pulse writes `cfg_mode` and `cfg_mask` into `mode_q` and `mask_q`. If it coincides with a clearing refresh, the clear wins.
- R10: After reset, `refresh_stb`, `rsv_err` and `dq_oe` are 0 and `refresh_row` is 0. `refresh_stb` is a single-cycle pulse and occurs at most once per row-strobe low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| re_n | input | 1 | Row strobe, active low |
| ce_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | ROW_W | Row address pins |
| cfg_load | input | 1 | Side-port load strobe for mode and mask |
| cfg_mode | input | MODE_W | Mode value to load |
| cfg_mask | input | MASK_W | Mask value to load |
| refresh_stb | output | 1 | One-cycle pulse per refresh |
| refresh_row | output | ROW_W | Row to refresh, valid with the strobe |
| refresh_kind | output | 2 | 0 address row, 1 counter with clear, 2 counter with keep |
| dq_oe | output | 1 | Data output enable |
| rsv_err | output | 1 | One-cycle pulse on the reserved combination |
| mode_q | output | MODE_W | Special-mode register |
| mask_q | output | MASK_W | Persistent write-mask register |

## Verification
On every cycle the assertions check several properties:

- the strobe is a single-cycle pulse;
- the data outputs are off when a refresh strobe fires;
- the error pulse never coincides with a strobe;
- mode and mask read zero at a clearing refresh and are held at a keeping refresh;
- the counter sits one row past each counter-driven refresh;
- side-port loads land unless a clear takes priority.

Only the bench scenarios can show the following:

- that the row of an address refresh is the one present at the row-strobe fall rather than later;
- that a late column-strobe fall turns the cycle into an access;
- that address refreshes and reserved cycles leave the counter alone;
- that the counter wraps after a full pass of rows.

// File: rtl/vrd_pkg.sv
// Shared types for the refresh cycle decoder.
package vrd_pkg;
    // Refresh kind reported with each strobe.
    typedef enum logic [1:0] {
        RK_ADDR_ROW  = 2'd0,
        RK_CTR_CLEAR = 2'd1,
        RK_CTR_KEEP  = 2'd2,
        RK_NONE      = 2'd3
    } rfsh_kind_e;

    // Classifier state across one row-strobe low period.
    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_ROWP = 2'd1,
        CS_ACC  = 2'd2,
        CS_CTR  = 2'd3
    } cls_state_e;
endpackage

// File: rtl/vrd_pin_sampler.sv
// Registers the strobe and address pins once and derives row-strobe edges.
// Assumes pins are stable for at least one clock around each change.
module vrd_pin_sampler #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             dsf,
    input  logic [ROW_W-1:0] addr,
    output logic             s_ce_n,
    output logic             s_we_n,
    output logic             s_dsf,
    output logic             s_re_n,
    output logic [ROW_W-1:0] s_addr,
    output logic             re_fall,
    output logic             re_rise
);
    logic s_re_d;

    // Sample all pins and keep one delayed copy of the row strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_re_n <= 1'b1;
            s_re_d <= 1'b1;
            s_ce_n <= 1'b1;
            s_we_n <= 1'b1;
            s_dsf  <= 1'b0;
            s_addr <= '0;
        end else begin
            s_re_n <= re_n;
            s_re_d <= s_re_n;
            s_ce_n <= ce_n;
            s_we_n <= we_n;
            s_dsf  <= dsf;
            s_addr <= addr;
        end
    end

    assign re_fall = s_re_d & ~s_re_n;
    assign re_rise = ~s_re_d & s_re_n;
endmodule

// File: rtl/vrd_classifier.sv
// Classifies each row-strobe low period and emits one-cycle refresh events.
// Assumes sampled pins; column strobe low at the fall sample means it led.
module vrd_classifier
    import vrd_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_ce_n,
    input  logic             s_we_n,
    input  logic             s_dsf,
    input  logic             s_re_n,
    input  logic [ROW_W-1:0] s_addr,
    input  logic             re_fall,
    input  logic             re_rise,
    output logic             evt_valid,
    output rfsh_kind_e       evt_kind,
    output logic             evt_rsv,
    output logic [ROW_W-1:0] evt_row,
    output logic             dq_en
);
    cls_state_e       state;
    logic [ROW_W-1:0] row_lat;

    // Track the cycle type and latch the pin row at the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CS_IDLE;
            row_lat <= '0;
        end else if (re_fall) begin
            state <= s_ce_n ? CS_ROWP : CS_CTR;
            if (s_ce_n) row_lat <= s_addr;
        end else if (re_rise) begin
            state <= CS_IDLE;
        end else if (state == CS_ROWP && !s_re_n && !s_ce_n) begin
            state <= CS_ACC;
        end
    end

    // Decode refresh and reserved events for the current cycle.
    always_comb begin
        evt_valid = 1'b0;
        evt_kind  = RK_NONE;
        evt_rsv   = 1'b0;
        evt_row   = row_lat;
        if (re_fall && !s_ce_n) begin
            if (!s_dsf) begin
                evt_valid = 1'b1;
                evt_kind  = RK_CTR_CLEAR;
            end else if (s_we_n) begin
                evt_valid = 1'b1;
                evt_kind  = RK_CTR_KEEP;
            end else begin
                evt_rsv = 1'b1;
            end
        end else if (re_rise && state == CS_ROWP) begin
            evt_valid = 1'b1;
            evt_kind  = RK_ADDR_ROW;
        end
    end

    assign dq_en = (state == CS_ACC) && !s_ce_n && s_we_n;
endmodule

// File: rtl/vrd_row_counter.sv
// Internal refresh row counter; steps on request, wraps at 2**ROW_W.
module vrd_row_counter #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    // Clear on reset, advance by one per counter refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/vrd_mode_regs.sv
// Special-mode and persistent mask registers. Not reset: they hold an
// undefined pattern until a clearing refresh or a side-port load.
module vrd_mode_regs #(
    parameter int MODE_W = 4,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [MODE_W-1:0] load_mode,
    input  logic [MASK_W-1:0] load_mask,
    output logic [MODE_W-1:0] mode,
    output logic [MASK_W-1:0] mask
);
    // Clear has priority over a load in the same cycle.
    always_ff @(posedge clk) begin
        if (rst_n && clr) begin
            mode <= '0;
            mask <= '0;
        end else if (rst_n && load) begin
            mode <= load_mode;
            mask <= load_mask;
        end
    end
endmodule

// File: rtl/vram_refresh_decoder.sv
// Top: samples pins, classifies cycles, drives refresh strobe, row and kind.
// Assumes one clock domain; all pin inputs are asynchronous to nothing else.
module vram_refresh_decoder
    import vrd_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int MODE_W = 4,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              dsf,
    input  logic [ROW_W-1:0]  addr,
    input  logic              cfg_load,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [MASK_W-1:0] cfg_mask,
    output logic              refresh_stb,
    output logic [ROW_W-1:0]  refresh_row,
    output logic [1:0]        refresh_kind,
    output logic              dq_oe,
    output logic              rsv_err,
    output logic [MODE_W-1:0] mode_q,
    output logic [MASK_W-1:0] mask_q
);
    logic             s_ce_n, s_we_n, s_dsf, s_re_n, re_fall, re_rise;
    logic [ROW_W-1:0] s_addr, evt_row, ctr_q;
    logic             evt_valid, evt_rsv, dq_en, ctr_step, clr_modes;
    rfsh_kind_e       evt_kind;

    vrd_pin_sampler #(.ROW_W(ROW_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .re_n(re_n), .ce_n(ce_n), .we_n(we_n),
        .dsf(dsf), .addr(addr), .s_ce_n(s_ce_n), .s_we_n(s_we_n),
        .s_dsf(s_dsf), .s_re_n(s_re_n), .s_addr(s_addr),
        .re_fall(re_fall), .re_rise(re_rise)
    );

    vrd_classifier #(.ROW_W(ROW_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .s_ce_n(s_ce_n), .s_we_n(s_we_n),
        .s_dsf(s_dsf), .s_re_n(s_re_n), .s_addr(s_addr),
        .re_fall(re_fall), .re_rise(re_rise), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_rsv(evt_rsv), .evt_row(evt_row),
        .dq_en(dq_en)
    );

    assign ctr_step  = evt_valid && (evt_kind != RK_ADDR_ROW);
    assign clr_modes = evt_valid && (evt_kind == RK_CTR_CLEAR);

    vrd_row_counter #(.ROW_W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step(ctr_step), .row(ctr_q)
    );

    vrd_mode_regs #(.MODE_W(MODE_W), .MASK_W(MASK_W)) u_modes (
        .clk(clk), .rst_n(rst_n), .clr(clr_modes), .load(cfg_load),
        .load_mode(cfg_mode), .load_mask(cfg_mask),
        .mode(mode_q), .mask(mask_q)
    );

    // Register the refresh outputs; counter kinds take the counter row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_stb  <= 1'b0;
            refresh_row  <= '0;
            refresh_kind <= 2'd0;
            rsv_err      <= 1'b0;
        end else begin
            refresh_stb <= evt_valid;
            rsv_err     <= evt_rsv;
            if (evt_valid) begin
                refresh_row  <= (evt_kind == RK_ADDR_ROW) ? evt_row : ctr_q;
                refresh_kind <= evt_kind;
            end
        end
    end

    assign dq_oe = dq_en;
endmodule

// File: rtl/vrd_checker.sv
// Cycle properties of the refresh decoder, bound to the top module.
module vrd_checker #(
    parameter int ROW_W  = 9,
    parameter int MODE_W = 4,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              refresh_stb,
    input logic [ROW_W-1:0]  refresh_row,
    input logic [1:0]        refresh_kind,
    input logic              dq_oe,
    input logic              rsv_err,
    input logic [MODE_W-1:0] mode_q,
    input logic [MASK_W-1:0] mask_q,
    input logic              cfg_load,
    input logic [MODE_W-1:0] cfg_mode,
    input logic [MASK_W-1:0] cfg_mask,
    input logic [ROW_W-1:0]  ctr_q
);
    p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |=> !refresh_stb);

    p_dq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_stb || rsv_err) |-> !dq_oe);

    p_rsv_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |-> !refresh_stb);

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_stb && refresh_kind == 2'd1) |-> (mode_q == '0 && mask_q == '0));

    p_keep_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_stb && refresh_kind == 2'd2 && !$past(cfg_load))
        |-> ($stable(mode_q) && $stable(mask_q)));

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_stb && refresh_kind != 2'd0)
        |-> (ctr_q == ROW_W'(refresh_row + 1'b1)));

    p_load_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_load && rst_n) && !(refresh_stb && refresh_kind == 2'd1))
        |-> (mode_q == $past(cfg_mode) && mask_q == $past(cfg_mask)));
endmodule

bind vram_refresh_decoder vrd_checker #(
    .ROW_W(ROW_W), .MODE_W(MODE_W), .MASK_W(MASK_W)
) u_vrd_checker (
    .clk(clk), .rst_n(rst_n), .refresh_stb(refresh_stb),
    .refresh_row(refresh_row), .refresh_kind(refresh_kind), .dq_oe(dq_oe),
    .rsv_err(rsv_err), .mode_q(mode_q), .mask_q(mask_q),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
    .ctr_q(ctr_q)
);

// File: tb/vram_refresh_decoder_tb.sv
module vram_refresh_decoder_tb;
    localparam int ROW_W = 9, MODE_W = 4, MASK_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic re_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, dsf = 1'b0, cfg_load = 1'b0;
    logic [ROW_W-1:0]  addr = '0;
    logic [MODE_W-1:0] cfg_mode = '0;
    logic [MASK_W-1:0] cfg_mask = '0;
    logic refresh_stb, dq_oe, rsv_err;
    logic [ROW_W-1:0]  refresh_row;
    logic [1:0]        refresh_kind;
    logic [MODE_W-1:0] mode_q;
    logic [MASK_W-1:0] mask_q;

    int checks = 0, errors = 0;
    int stb_cnt = 0, err_cnt = 0, dq_cnt = 0;
    logic [ROW_W-1:0]  last_row = '0;
    logic [1:0]        last_kind = '0;
    logic [ROW_W-1:0]  exp_ctr = '0;
    logic [MODE_W-1:0] exp_mode = '0;
    logic [MASK_W-1:0] exp_mask = '0;
    bit known = 0;
    bit done = 0;

    vram_refresh_decoder #(.ROW_W(ROW_W), .MODE_W(MODE_W), .MASK_W(MASK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .re_n(re_n), .ce_n(ce_n), .we_n(we_n),
        .dsf(dsf), .addr(addr), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_mask(cfg_mask), .refresh_stb(refresh_stb),
        .refresh_row(refresh_row), .refresh_kind(refresh_kind),
        .dq_oe(dq_oe), .rsv_err(rsv_err), .mode_q(mode_q), .mask_q(mask_q)
    );

    always #10 clk = ~clk;

    // Monitor strobe, error and data-enable activity away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (refresh_stb) begin
                stb_cnt++;
                last_row  = refresh_row;
                last_kind = refresh_kind;
            end
            if (rsv_err) err_cnt++;
            if (dq_oe) dq_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Kind code the requirements assign to a counter refresh.
    function automatic int ctr_kind(input bit d, input bit w);
        if (!d) return 1;
        if (w) return 2;
        return -1;
    endfunction

    task automatic check_modes(input string req);
        if (known) begin
            check(req, int'(mode_q), int'(exp_mode));
            check(req, int'(mask_q), int'(exp_mask));
        end
    endtask

    // Address-row refresh; pins change after the fall to test latching.
    task automatic do_addr_refresh(input logic [ROW_W-1:0] row);
        int s0 = stb_cnt, d0 = dq_cnt;
        addr = row; ce_n = 1'b1;
        idle(1); re_n = 1'b0;
        idle(3); addr = ~row;
        idle(2); re_n = 1'b1;
        idle(4);
        check("R1 strobes", stb_cnt - s0, 1);
        check("R1 row", int'(last_row), int'(row));
        check("R1 kind", int'(last_kind), 0);
        check("R7 dq addr-row", dq_cnt - d0, 0);
        check_modes("R5 modes kept");
    endtask

    // Column strobe leads the row strobe; dsf/we pick the variant.
    task automatic do_ctr_cycle(input bit d, input bit w, input bit load_mid);
        int s0 = stb_cnt, e0 = err_cnt, q0 = dq_cnt;
        int k = ctr_kind(d, w);
        logic [MODE_W-1:0] lm = MODE_W'($urandom);
        logic [MASK_W-1:0] lk = MASK_W'($urandom);
        ce_n = 1'b0; dsf = d; we_n = w;
        idle(2); re_n = 1'b0;
        if (load_mid) begin
            idle(1); cfg_load = 1'b1; cfg_mode = lm; cfg_mask = lk;
            idle(1); cfg_load = 1'b0;
            idle(1);
        end else idle(3);
        re_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
        idle(4);
        check("R7 dq counter cycle", dq_cnt - q0, 0);
        if (k < 0) begin
            check("R6 err pulse", err_cnt - e0, 1);
            check("R6 no strobe", stb_cnt - s0, 0);
            check_modes("R6 modes kept");
        end else begin
            check("R10 one strobe", stb_cnt - s0, 1);
            check(k == 1 ? "R2 kind" : "R3 kind", int'(last_kind), k);
            check("R4 counter row", int'(last_row), int'(exp_ctr));
            exp_ctr = exp_ctr + 1'b1;
            if (k == 1) begin
                known = 1; exp_mode = '0; exp_mask = '0;
                check_modes(load_mid ? "R9 clear wins" : "R2 cleared");
            end else check_modes("R3 modes kept");
        end
    endtask

    // Ordinary access: column strobe falls after the row strobe.
    task automatic do_access(input bit rd);
        int s0 = stb_cnt, q0 = dq_cnt;
        ce_n = 1'b1; idle(1);
        re_n = 1'b0; idle(2);
        ce_n = 1'b0; we_n = rd; idle(4);
        ce_n = 1'b1; re_n = 1'b1; we_n = 1'b1; idle(4);
        check("R8 no strobe", stb_cnt - s0, 0);
        check("R8 dq enable", (dq_cnt - q0) > 0 ? 1 : 0, rd ? 1 : 0);
        check_modes("R8 modes kept");
    endtask

    task automatic do_load();
        cfg_mode = MODE_W'($urandom); cfg_mask = MASK_W'($urandom);
        cfg_load = 1'b1; idle(1); cfg_load = 1'b0; idle(1);
        known = 1; exp_mode = cfg_mode; exp_mask = cfg_mask;
        check_modes("R9 load");
    endtask

    initial begin
        void'($urandom(32'd20517));
        idle(3);
        check("R10 reset stb", int'(refresh_stb), 0);
        check("R10 reset err", int'(rsv_err), 0);
        check("R10 reset dq", int'(dq_oe), 0);
        check("R10 reset row", int'(refresh_row), 0);
        rst_n = 1'b1;
        idle(2);
        // Directed corners.
        do_ctr_cycle(1'b0, 1'b0, 1'b0);
        do_load();
        do_ctr_cycle(1'b1, 1'b1, 1'b0);
        do_addr_refresh(9'd511);
        do_ctr_cycle(1'b1, 1'b0, 1'b0);
        do_access(1'b1);
        do_access(1'b0);
        do_load();
        do_ctr_cycle(1'b0, 1'b1, 1'b1);
        // Full pass to show the wrap.
        for (int i = 0; i < 515; i++) do_ctr_cycle(1'b1, 1'b1, 1'b0);
        // Random mix.
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 6)
                0: do_addr_refresh(ROW_W'($urandom));
                1: do_ctr_cycle(1'b0, 1'($urandom), 1'($urandom));
                2: do_ctr_cycle(1'b1, 1'b1, 1'b0);
                3: do_ctr_cycle(1'b1, 1'b0, 1'b0);
                4: do_access(1'($urandom));
                default: do_load();
            endcase
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (150000) @(posedge clk); end
        join_any
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule